// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Controller

This block connects a synchronous request port to an external asynchronous static RAM that holds words of two byte lanes. A system-side master offers a request with a word address, a read/write flag, write data and a two-bit lane mask. The controller turns it into a correctly timed memory cycle on the active-low chip select, write strobe, output enable and per-lane strobe pins, the address bus and a shared tri-state data bus. The length of every phase is a whole number of clocks. Each count is derived from a nanosecond figure and the clock period given as parameters.

The request side is a valid/ready channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The master must hold `req_valid` and every request field until that edge. `req_ready` stays low for the whole memory cycle and any turnaround that follows it, so only one access is ever in flight. Read results come back on a one-clock `rsp_valid` pulse that cannot be stalled. A master that needs the data has to capture it in that cycle.

A write raises its write strobe while chip select, address and lane strobes are all still held. The memory latches data on that rising edge. The controller drives the data bus only after the write strobe has turned the memory's outputs off. After every read, it spends idle clocks with output enable high before it takes another request.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, chip select, write strobe, output enable and both lane strobes are high, `req_ready` is high and `rsp_valid` is low.
- R2: A request is accepted only on an edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the cycle (and any turnaround) is complete. After a write it returns S+W+1 clocks after the accepting edge. After a read it returns A+T clocks after the accepting edge.
- R3: A write holds chip select low with the write strobe high for S clocks. The write strobe is then low for W clocks. A final clock follows with the write strobe high and chip select still low. The write strobe only rises while chip select is low.
- R4: Mask bit 0 selects the lower lane (data bits 7:0) and mask bit 1 selects the upper lane (bits 15:8). While chip select is low, the lower lane strobe is low exactly when mask bit 0 is 1, and the upper lane strobe is low exactly when mask bit 1 is 1.
- R5: A write changes only the lanes selected in its mask. With mask 0 it changes no stored data.
- R6: The controller drives the data bus only from one clock after the write strobe falls until one clock after it rises. It never drives while output enable is low. The data on the bus at the rising write strobe is the request's write data.
- R7: A read holds chip select and output enable low with the write strobe high for A clocks. Output enable is never low while the write strobe is low.
- R8: Read data is sampled on the last access clock. `rsp_valid` is high for exactly one clock, A+1 clocks after the accepting edge counted as clock 1, with lanes not selected in the mask returned as zero.
- R9: After every read, chip select and output enable stay high for T clocks before `req_ready` returns.
- R10: While chip select stays low, the address and lane strobes do not change.
- R11: The counts are S = max(1, ceil(AS/P)), W = max(ceil(WP/P), 1 + ceil(DS/P)), A = max(1, ceil(AA/P)) and T = max(1, ceil(TZ/P)), with P the clock period in ns.
- R12: While chip select is high, the write strobe and output enable are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 2*LANE_W | Write data |
| req_be | input | 2 | Lane mask, bit 0 lower lane, bit 1 upper lane |
| rsp_valid | output | 1 | One-clock read-data pulse |
| rsp_rdata | output | 2*LANE_W | Read data, unselected lanes zero |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_lb_n | output | 1 | Lower lane strobe, active low |
| sram_ub_n | output | 1 | Upper lane strobe, active low |
| sram_addr | output | ADDR_W | Memory address |
| sram_dq | inout | 2*LANE_W | Shared data bus |

## Verification
Clocks are counted from the accepting edge, taken as clock 1. A write returns `req_ready` in clock S+W+2. A read shows `rsp_valid` in clock A+1 and `req_ready` in clock A+T+1. The bench drives and samples on falling edges and counts every falling edge after acceptance. It records the clock in which each result appears and compares that index with the value it computes from the timing formulas. It also counts setup, strobe and output-enable clocks inside that same walk. The memory model beside the bench latches data on the rising write strobe, so read-back values show which lanes each write changed.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WPUL,
    ST_WEND,
    ST_RACC,
    ST_TURN
  } asram_st_e;

  function automatic int cyc_ceil(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int at_least(input int v, input int floor_v);
    return (v < floor_v) ? floor_v : v;
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int S_CYC = 1,
  parameter int W_CYC = 2,
  parameter int A_CYC = 1,
  parameter int T_CYC = 1,
  parameter int CNT_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_fire,
  input  logic req_we,
  output logic req_ready,
  output logic ce_n,
  output logic we_n,
  output logic oe_n,
  output logic cap_now
);

  asram_st_e        st;
  logic [CNT_W-1:0] cnt;
  logic             cnt_done;

  assign cnt_done = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_fire) begin
          st  <= req_we ? ST_WSET : ST_RACC;
          cnt <= req_we ? CNT_W'(S_CYC - 1) : CNT_W'(A_CYC - 1);
        end
        ST_WSET: if (cnt_done) begin
          st  <= ST_WPUL;
          cnt <= CNT_W'(W_CYC - 1);
        end else cnt <= cnt - 1'b1;
        ST_WPUL: if (cnt_done) st <= ST_WEND;
                 else cnt <= cnt - 1'b1;
        ST_WEND: st <= ST_IDLE;
        ST_RACC: if (cnt_done) begin
          st  <= ST_TURN;
          cnt <= CNT_W'(T_CYC - 1);
        end else cnt <= cnt - 1'b1;
        ST_TURN: if (cnt_done) st <= ST_IDLE;
                 else cnt <= cnt - 1'b1;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready = (st == ST_IDLE);
    ce_n      = !(st == ST_WSET || st == ST_WPUL || st == ST_WEND || st == ST_RACC);
    we_n      = (st != ST_WPUL);
    oe_n      = (st != ST_RACC);
    cap_now   = (st == ST_RACC) && cnt_done;
  end

  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (we_n && oe_n)); // R12
  AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n); // R7
  AST_WE_RISE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> !ce_n); // R3
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ce_n); // R2

endmodule

// File: rtl/asram_bus.sv
module asram_bus #(
  parameter int ADDR_W = 16,
  parameter int LANE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_fire,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [LANES*LANE_W-1:0] req_wdata,
  input  logic [LANES-1:0]        req_be,
  input  logic                    ce_n,
  input  logic                    we_n,
  input  logic                    oe_n,
  output logic [ADDR_W-1:0]       addr,
  output logic [LANES-1:0]        lane_n,
  output logic [LANES-1:0]        be_q,
  inout  wire  [LANES*LANE_W-1:0] dq
);

  logic [LANES*LANE_W-1:0] wdata_q;
  logic                    drv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr    <= '0;
      be_q    <= '0;
      wdata_q <= '0;
    end else if (req_fire) begin
      addr    <= req_addr;
      be_q    <= req_be;
      wdata_q <= req_wdata;
    end
  end

  // bus turns on a clock after the write strobe falls, off a clock after it rises
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_q <= 1'b0;
    else        drv_q <= !we_n;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_n[g] = ce_n | !be_q[g];
    assign dq[g*LANE_W +: LANE_W] = drv_q ? wdata_q[g*LANE_W +: LANE_W] : {LANE_W{1'bz}};
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && $past(!ce_n)) |-> ($stable(addr) && $stable(lane_n))); // R10
  AST_DRV_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    drv_q |-> ($past(we_n) == 1'b0)); // R6
  AST_DRV_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    drv_q |-> oe_n); // R6

endmodule

// File: rtl/asram_rcap.sv
module asram_rcap #(
  parameter int LANE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap_now,
  input  logic [LANES-1:0]        be_q,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic                    rsp_valid,
  output logic [LANES*LANE_W-1:0] rsp_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= cap_now;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rsp_rdata[g*LANE_W +: LANE_W] <= '0;
      else if (cap_now)
        rsp_rdata[g*LANE_W +: LANE_W] <= be_q[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
    end
  end

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R8
  AST_RSP_FROM_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(cap_now)); // R8

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int LANE_W  = 8,
  parameter int CLK_NS  = 10,
  parameter int AS_NS   = 8,
  parameter int WP_NS   = 7,
  parameter int DS_NS   = 5,
  parameter int AA_NS   = 10,
  parameter int TZ_NS   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_we,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [2*LANE_W-1:0]   req_wdata,
  input  logic [1:0]            req_be,
  output logic                  rsp_valid,
  output logic [2*LANE_W-1:0]   rsp_rdata,
  output logic                  sram_ce_n,
  output logic                  sram_we_n,
  output logic                  sram_oe_n,
  output logic                  sram_lb_n,
  output logic                  sram_ub_n,
  output logic [ADDR_W-1:0]     sram_addr,
  inout  wire  [2*LANE_W-1:0]   sram_dq
);

  localparam int LANES = 2;
  localparam int S_CYC = at_least(cyc_ceil(AS_NS, CLK_NS), 1);
  localparam int W_CYC = at_least(cyc_ceil(WP_NS, CLK_NS), 1 + cyc_ceil(DS_NS, CLK_NS));
  localparam int A_CYC = at_least(cyc_ceil(AA_NS, CLK_NS), 1);
  localparam int T_CYC = at_least(cyc_ceil(TZ_NS, CLK_NS), 1);
  localparam int MAX_C = max4(S_CYC, W_CYC, A_CYC, T_CYC);
  localparam int CNT_W = at_least($clog2(MAX_C + 1), 1);

  logic             req_fire;
  logic             cap_now;
  logic [LANES-1:0] lane_n;
  logic [LANES-1:0] be_q;

  assign req_fire  = req_valid & req_ready;
  assign sram_lb_n = lane_n[0];
  assign sram_ub_n = lane_n[1];

  asram_seq #(
    .S_CYC(S_CYC), .W_CYC(W_CYC), .A_CYC(A_CYC), .T_CYC(T_CYC), .CNT_W(CNT_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_fire (req_fire),
    .req_we   (req_we),
    .req_ready(req_ready),
    .ce_n     (sram_ce_n),
    .we_n     (sram_we_n),
    .oe_n     (sram_oe_n),
    .cap_now  (cap_now)
  );

  asram_bus #(
    .ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)
  ) u_bus (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_fire (req_fire),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .req_be   (req_be),
    .ce_n     (sram_ce_n),
    .we_n     (sram_we_n),
    .oe_n     (sram_oe_n),
    .addr     (sram_addr),
    .lane_n   (lane_n),
    .be_q     (be_q),
    .dq       (sram_dq)
  );

  asram_rcap #(
    .LANE_W(LANE_W), .LANES(LANES)
  ) u_rcap (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_now  (cap_now),
    .be_q     (be_q),
    .dq_in    (sram_dq),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

  AST_ACCEPT_STARTS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> (!sram_ce_n && !req_ready)); // R2

endmodule

// File: tb/asram_ctrl_bench.sv
module asram_ctrl_bench;

  localparam int CLK_NS = 4;
  localparam int AW     = 4;
  localparam int DEPTH  = 1 << AW;
  // expected phase counts from the R11 formulas with AS=8, WP=7, DS=5, AA=10, TZ=4
  localparam int S_EXP = ((8 + CLK_NS - 1) / CLK_NS) < 1 ? 1 : ((8 + CLK_NS - 1) / CLK_NS);
  localparam int WA    = (7 + CLK_NS - 1) / CLK_NS;
  localparam int WB    = 1 + (5 + CLK_NS - 1) / CLK_NS;
  localparam int W_EXP = WA > WB ? WA : WB;
  localparam int A_EXP = ((10 + CLK_NS - 1) / CLK_NS) < 1 ? 1 : ((10 + CLK_NS - 1) / CLK_NS);
  localparam int T_EXP = ((4 + CLK_NS - 1) / CLK_NS) < 1 ? 1 : ((4 + CLK_NS - 1) / CLK_NS);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic [1:0]    req_be = '0;
  logic          rsp_valid;
  logic [15:0]   rsp_rdata;
  logic          ce_n, we_n, oe_n, lb_n, ub_n;
  logic [AW-1:0] sram_addr;
  wire  [15:0]   dq;

  int total = 0;
  int bad   = 0;
  int standby_bad = 0;

  always #(CLK_NS / 2) clk = ~clk;

  asram_ctrl #(
    .ADDR_W(AW), .LANE_W(8), .CLK_NS(CLK_NS),
    .AS_NS(8), .WP_NS(7), .DS_NS(5), .AA_NS(10), .TZ_NS(4)
  ) u_asram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_ce_n(ce_n), .sram_we_n(we_n), .sram_oe_n(oe_n),
    .sram_lb_n(lb_n), .sram_ub_n(ub_n), .sram_addr(sram_addr), .sram_dq(dq)
  );

  // behavioural memory: latches on rising write strobe, drives on read
  logic [15:0] mem [DEPTH];
  always @(posedge we_n) begin
    if (rst_n && !ce_n) begin
      if (!lb_n) mem[sram_addr][7:0]  <= dq[7:0];
      if (!ub_n) mem[sram_addr][15:8] <= dq[15:8];
    end
  end
  assign dq[7:0]  = (!ce_n && we_n && !oe_n && !lb_n) ? mem[sram_addr][7:0]  : 8'bz;
  assign dq[15:8] = (!ce_n && we_n && !oe_n && !ub_n) ? mem[sram_addr][15:8] : 8'bz;

  // R12 monitor
  always @(negedge clk) if (rst_n && ce_n && (!we_n || !oe_n)) standby_bad++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] lane_mask(input logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  function automatic logic [15:0] pat_a(input int a);
    return 16'(a * 16'h0913 + 16'h3C5A);
  endfunction

  function automatic logic [15:0] pat_b(input int a);
    return 16'(a * 16'h1F07 ^ 16'hC3A9);
  endfunction

  task automatic do_write(input int a, input logic [15:0] d, input logic [1:0] m);
    int k, pre, wlo, olo, hold_bad;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = AW'(a); req_wdata = d; req_be = m;
    @(negedge clk);
    req_valid = 1'b0;
    k = 1; pre = 0; wlo = 0; olo = 0; hold_bad = 0;
    while (!req_ready) begin
      if (!we_n) wlo++;
      else if (!ce_n && wlo == 0) pre++;
      if (!oe_n) olo++;
      if (!ce_n && (sram_addr != AW'(a) || lb_n != !m[0] || ub_n != !m[1])) hold_bad++;
      k++;
      @(negedge clk);
    end
    chk(k == S_EXP + W_EXP + 2, "R2 write ready clock", k, S_EXP + W_EXP + 2);
    chk(pre == S_EXP, "R3 R11 setup clocks", pre, S_EXP);
    chk(wlo == W_EXP, "R3 R11 strobe clocks", wlo, W_EXP);
    chk(olo == 0, "R6 R7 oe low during write", olo, 0);
    chk(hold_bad == 0, "R4 R10 addr/lane hold", hold_bad, 0);
  endtask

  task automatic do_read(input int a, input logic [1:0] m, output logic [15:0] d);
    int k, rk, pulses, olo, turn_bad;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = AW'(a); req_be = m;
    @(negedge clk);
    req_valid = 1'b0;
    k = 1; rk = 0; pulses = 0; olo = 0; turn_bad = 0; d = '0;
    while (!req_ready) begin
      if (!oe_n && !ce_n && we_n) olo++;
      if (rsp_valid) begin pulses++; rk = k; d = rsp_rdata; end
      if (k > A_EXP && (!ce_n || !oe_n)) turn_bad++;
      k++;
      @(negedge clk);
    end
    chk(k == A_EXP + T_EXP + 1, "R2 R9 read ready clock", k, A_EXP + T_EXP + 1);
    chk(rk == A_EXP + 1, "R8 rsp clock", rk, A_EXP + 1);
    chk(pulses == 1, "R8 single pulse", pulses, 1);
    chk(olo == A_EXP, "R7 R11 access clocks", olo, A_EXP);
    chk(turn_bad == 0, "R9 turnaround quiet", turn_bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ce_n && we_n && oe_n && lb_n && ub_n, "R1 pins in reset",
        {27'd0, ce_n, we_n, oe_n, lb_n, ub_n}, 5'h1f);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);

    // full-word fill
    for (int a = 0; a < DEPTH; a++) do_write(a, pat_a(a), 2'b11);

    // every address under every lane mask
    for (int a = 0; a < DEPTH; a++) begin
      for (int m = 0; m < 4; m++) begin
        logic [15:0] got, exp;
        do_read(a, 2'(m), got);
        exp = pat_a(a) & lane_mask(2'(m));
        chk(got == exp, "R8 R6 read data masked", got, exp);
      end
    end

    // partial writes: mask cycles through 0..3, then full read-back
    for (int a = 0; a < DEPTH; a++) begin
      logic [1:0]  m;
      logic [15:0] got, exp;
      m = 2'(a % 4);
      do_write(a, pat_b(a), m);
      do_read(a, 2'b11, got);
      exp = (pat_b(a) & lane_mask(m)) | (pat_a(a) & ~lane_mask(m));
      chk(got == exp, "R5 R4 R6 lane merge", got, exp);
    end

    // back-to-back read then write then read at one address
    begin
      logic [15:0] got;
      do_read(3, 2'b01, got);
      do_write(3, 16'hA55A, 2'b11);
      do_read(3, 2'b11, got);
      chk(got == 16'hA55A, "R9 R6 write after read", got, 16'hA55A);
    end

    chk(standby_bad == 0, "R12 standby strobes", standby_bad, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 200000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule